// File: doc/BRIEF.md
# Page Permission Fault Checker

This block sits after a page-table walker. For every translated access it receives the walker's verdict: whether a leaf entry was found, and that entry's low permission bits. It also receives the access kind (instruction fetch, load or store), the current privilege mode, the make-executable-readable (MXR) status bit, the supervisor-user-access (SUM) status bit and the virtual address. It decides whether the access may proceed. If it may not, the block reports a page fault whose cause matches the access kind, and it returns the virtual address as the trap value.

Requests arrive on a valid/ready input. Results leave on a valid/ready output held in a single register stage. `req_ready_o` equals `!res_valid_o || res_ready_i`. A result that is not taken stays unchanged, and while it is held no new request is accepted. The decision logic is combinational. The fault, cause, trap value and a sticky trapped flag are all registered. Software clears the trapped flag with a one-cycle acknowledge once the trap has been handled.

Top module: `pte_perm_checker`

## Requirements
- R1: While reset is held and after its release, `res_valid_o` is 0, `trapped_o` is 0 and `req_ready_o` is 1.
- R2: An access faults when no entry was found (`pte_found_i`=0), or when the valid bit (flag bit 0) is 0. The flag bits are V=bit 0, R=bit 1, W=bit 2, X=bit 3 and U=bit 4.
- R3: A fetch (`access_i`=0) faults unless X=1. A store (`access_i`=2) faults unless W=1.
- R4: A load (`access_i`=1) with MXR=0 faults unless R=1. With MXR=1, a load succeeds if R=1 or X=1.
- R5: In supervisor mode (`priv_i`=1) with SUM=0, any access to a page with U=1 faults. With SUM=1, or in user mode (0) or machine mode (3), the U bit causes no fault.
- R6: On a fault, `res_cause_o` is 12 for a fetch, 13 for a load and 15 for a store. On an allowed access it is 0, and `res_fault_o` is 0.
- R7: On a fault, `res_tval_o` equals the request's virtual address. On an allowed access it is 0.
- R8: A request accepted at a clock edge yields `res_valid_o`=1 with its result after that same edge. If the result is not taken, it is held stable and `req_ready_o` is 0.
- R9: `trapped_o` becomes 1 after the edge that accepts a faulting request. It clears after an edge with `trap_ack_i`=1. If a new fault is accepted at the same edge as the acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| access_i | input | 2 | 0 fetch, 1 load, 2 store |
| priv_i | input | 2 | 0 user, 1 supervisor, 3 machine |
| mxr_i | input | 1 | Make-executable-readable status bit |
| sum_i | input | 1 | Supervisor-user-access status bit |
| pte_found_i | input | 1 | Walker found a leaf entry |
| pte_flags_i | input | 5 | Entry bits U,X,W,R,V (4..0) |
| vaddr_i | input | VA_W | Virtual address of the access |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Consumer takes result |
| res_fault_o | output | 1 | Access faulted |
| res_cause_o | output | CAUSE_W | Page-fault cause, 0 if allowed |
| res_tval_o | output | VA_W | Trap value |
| trapped_o | output | 1 | Sticky trapped flag |
| trap_ack_i | input | 1 | Clears the trapped flag |

## Verification
The assertions assume that `access_i` never carries the unused code 3, and that the consumer does not depend on a result's fields before `res_valid_o` is seen. The sweep drives only access codes 0 to 2 and privilege codes 0, 1 and 3. The back-pressure and acknowledge phases change `res_ready_i` and `trap_ack_i` only between clock edges. The exhaustive sweep covers every combination of access kind, privilege mode, MXR, SUM, found flag and the five flag bits.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int CAUSE_W   = 5;
  localparam int FLAGS_W   = 5;
  localparam int PRIV_W    = 2;
  localparam int ACC_W     = 2;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;

  localparam logic [PRIV_W-1:0] PRIV_SUP = 2'd1;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 5'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 5'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 5'd15;

  typedef enum logic [ACC_W-1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    VERDICT_OK      = 2'd0,
    VERDICT_INVALID = 2'd1,
    VERDICT_PERM    = 2'd2,
    VERDICT_SUM     = 2'd3
  } verdict_e;
endpackage

// File: rtl/pfc_rule_eval.sv
module pfc_rule_eval
  import pfc_pkg::*;
(
  input  acc_e                access,
  input  logic [PRIV_W-1:0]   priv,
  input  logic                mxr,
  input  logic                sum,
  input  logic                found,
  input  logic [FLAGS_W-1:0]  flags,
  output verdict_e            verdict,
  output logic                fault
);
  logic readable;
  logic has_perm;
  logic user_block;

  always_comb begin
    readable = flags[BIT_R] | (mxr & flags[BIT_X]);
    unique case (access)
      ACC_FETCH: has_perm = flags[BIT_X];
      ACC_LOAD:  has_perm = readable;
      ACC_STORE: has_perm = flags[BIT_W];
      default:   has_perm = 1'b0;
    endcase
    user_block = (priv == PRIV_SUP) & ~sum & flags[BIT_U];
  end

  always_comb begin
    if (!found || !flags[BIT_V])
      verdict = VERDICT_INVALID;
    else if (!has_perm)
      verdict = VERDICT_PERM;
    else if (user_block)
      verdict = VERDICT_SUM;
    else
      verdict = VERDICT_OK;
  end

  assign fault = (verdict != VERDICT_OK);
endmodule

// File: rtl/pfc_cause_map.sv
module pfc_cause_map
  import pfc_pkg::*;
(
  input  acc_e                access,
  input  logic                fault,
  output logic [CAUSE_W-1:0]  cause
);
  always_comb begin
    cause = CAUSE_NONE;
    if (fault) begin
      unique case (access)
        ACC_FETCH: cause = CAUSE_FETCH;
        ACC_LOAD:  cause = CAUSE_LOAD;
        ACC_STORE: cause = CAUSE_STORE;
        default:   cause = CAUSE_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pfc_out_stage.sv
module pfc_out_stage
  import pfc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take,
  input  logic                fault_in,
  input  logic [CAUSE_W-1:0]  cause_in,
  input  logic [VA_W-1:0]     vaddr_in,
  input  logic                res_ready,
  input  logic                ack,
  output logic                res_valid,
  output logic                res_fault,
  output logic [CAUSE_W-1:0]  res_cause,
  output logic [VA_W-1:0]     res_tval,
  output logic                trapped
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_cause <= CAUSE_NONE;
      res_tval  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_fault <= fault_in;
      res_cause <= cause_in;
      res_tval  <= fault_in ? vaddr_in : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      trapped <= 1'b0;
    else if (take && fault_in)
      trapped <= 1'b1;
    else if (ack)
      trapped <= 1'b0;
  end
endmodule

// File: rtl/pte_perm_checker.sv
module pte_perm_checker
  import pfc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          access_i,
  input  logic [1:0]          priv_i,
  input  logic                mxr_i,
  input  logic                sum_i,
  input  logic                pte_found_i,
  input  logic [4:0]          pte_flags_i,
  input  logic [VA_W-1:0]     vaddr_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic                res_fault_o,
  output logic [4:0]          res_cause_o,
  output logic [VA_W-1:0]     res_tval_o,
  output logic                trapped_o,
  input  logic                trap_ack_i
);
  acc_e               acc;
  verdict_e           verdict;
  logic               rule_fault;
  logic [CAUSE_W-1:0] cause_next;
  logic               take;

  assign acc         = acc_e'(access_i);
  assign req_ready_o = ~res_valid_o | res_ready_i;
  assign take        = req_valid_i & req_ready_o;

  pfc_rule_eval rule_i (
    .access  (acc),
    .priv    (priv_i),
    .mxr     (mxr_i),
    .sum     (sum_i),
    .found   (pte_found_i),
    .flags   (pte_flags_i),
    .verdict (verdict),
    .fault   (rule_fault)
  );

  pfc_cause_map cause_i (
    .access (acc),
    .fault  (rule_fault),
    .cause  (cause_next)
  );

  pfc_out_stage #(.VA_W(VA_W)) out_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take      (take),
    .fault_in  (rule_fault),
    .cause_in  (cause_next),
    .vaddr_in  (vaddr_i),
    .res_ready (res_ready_i),
    .ack       (trap_ack_i),
    .res_valid (res_valid_o),
    .res_fault (res_fault_o),
    .res_cause (res_cause_o),
    .res_tval  (res_tval_o),
    .trapped   (trapped_o)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [1:0]      access_i,
  input logic [1:0]      priv_i,
  input logic            sum_i,
  input logic            pte_found_i,
  input logic [4:0]      pte_flags_i,
  input logic [VA_W-1:0] vaddr_i,
  input logic            res_valid_o,
  input logic            res_ready_i,
  input logic            res_fault_o,
  input logic [4:0]      res_cause_o,
  input logic [VA_W-1:0] res_tval_o,
  input logic            trapped_o,
  input logic            rule_fault
);
  logic acc_q;
  assign acc_q = req_valid_i && req_ready_o;

  p_missing_fault_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q && (!pte_found_i || !pte_flags_i[0]) |=> res_valid_o && res_fault_o);

  p_sum_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q && priv_i == 2'd1 && !sum_i && pte_flags_i[4] |=> res_fault_o);

  p_fetch_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q && access_i == 2'd0 |=> (res_fault_o ? res_cause_o == 5'd12 : res_cause_o == 5'd0));

  p_load_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q && access_i == 2'd1 |=> (res_fault_o ? res_cause_o == 5'd13 : res_cause_o == 5'd0));

  p_tval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |=> res_tval_o == (res_fault_o ? $past(vaddr_i) : '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_fault_o)
      && $stable(res_cause_o) && $stable(res_tval_o));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |-> !req_ready_o);

  p_trap_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q && rule_fault |=> trapped_o);
endmodule

bind pte_perm_checker pfc_checker #(.VA_W(VA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .access_i    (access_i),
  .priv_i      (priv_i),
  .sum_i       (sum_i),
  .pte_found_i (pte_found_i),
  .pte_flags_i (pte_flags_i),
  .vaddr_i     (vaddr_i),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_fault_o (res_fault_o),
  .res_cause_o (res_cause_o),
  .res_tval_o  (res_tval_o),
  .trapped_o   (trapped_o),
  .rule_fault  (rule_fault)
);

// File: tb/pte_perm_checker_tb_top.sv
module pte_perm_checker_tb_top;
  localparam int VA_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      access = '0;
  logic [1:0]      priv = '0;
  logic            mxr = 1'b0;
  logic            sum = 1'b0;
  logic            found = 1'b0;
  logic [4:0]      flags = '0;
  logic [VA_W-1:0] vaddr = '0;
  logic            res_valid;
  logic            res_ready = 1'b1;
  logic            res_fault;
  logic [4:0]      res_cause;
  logic [VA_W-1:0] res_tval;
  logic            trapped;
  logic            trap_ack = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pte_perm_checker #(.VA_W(VA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .access_i(access), .priv_i(priv), .mxr_i(mxr), .sum_i(sum),
    .pte_found_i(found), .pte_flags_i(flags), .vaddr_i(vaddr),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_fault_o(res_fault),
    .res_cause_o(res_cause), .res_tval_o(res_tval), .trapped_o(trapped),
    .trap_ack_i(trap_ack)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_fault(input int a, input int p, input bit m, input bit s,
                                     input bit f, input logic [4:0] fl);
    bit perm;
    bit flt;
    flt = !f || !fl[0];                                         // R2
    if (a == 0) perm = fl[3];                                   // R3
    else if (a == 1) perm = fl[1] || (m && fl[3]);              // R4
    else perm = fl[2];                                          // R3
    flt = flt || !perm;
    flt = flt || (p == 1 && !s && fl[4]);                       // R5
    return flt;
  endfunction

  function automatic int model_cause(input int a, input bit flt);
    if (!flt) return 0;
    return (a == 0) ? 12 : (a == 1) ? 13 : 15;                  // R6
  endfunction

  initial begin
    #100000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 res_valid in reset", res_valid, 0);
    check("R1 trapped in reset", trapped, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_valid after reset", res_valid, 0);
    check("R1 trapped after reset", trapped, 0);
    check("R1 req_ready after reset", req_ready, 1);

    // exhaustive sweep: R2 R3 R4 R5 R6 R7 R8
    for (int a = 0; a < 3; a++)
      for (int pi = 0; pi < 3; pi++)
        for (int m = 0; m < 2; m++)
          for (int s = 0; s < 2; s++)
            for (int f = 0; f < 2; f++)
              for (int fl = 0; fl < 32; fl++) begin
                int p;
                bit ef;
                logic [VA_W-1:0] va;
                p = (pi == 2) ? 3 : pi;
                va = {a[3:0], pi[3:0], m[0], s[0], f[0], fl[4:0], 17'h1abc};
                access = a[1:0]; priv = p[1:0]; mxr = m[0]; sum = s[0];
                found = f[0]; flags = fl[4:0]; vaddr = va; req_valid = 1'b1;
                @(negedge clk);
                ef = model_fault(a, p, m[0], s[0], f[0], fl[4:0]);
                check("R8 res_valid", res_valid, 1);
                if (a == 1) check("R4 load fault", res_fault, ef);
                else if (p == 1) check("R5 fault", res_fault, ef);
                else check("R2/R3 fault", res_fault, ef);
                check("R6 cause", res_cause, model_cause(a, ef));
                check("R7 tval", res_tval, ef ? va : '0);
              end
    req_valid = 1'b0;
    @(negedge clk);
    check("R8 res_valid drops", res_valid, 0);

    // back-pressure R8
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
    check("R9 ack clears", trapped, 0);
    res_ready = 1'b0;
    access = 2'd2; priv = 2'd0; found = 1'b1; flags = 5'b00011; vaddr = 32'hdead0000;
    req_valid = 1'b1;
    @(negedge clk);
    check("R8 held valid", res_valid, 1);
    check("R6 store cause", res_cause, 15);
    check("R9 trapped set", trapped, 1);
    access = 2'd1; flags = 5'b00011; vaddr = 32'h11110000;
    @(negedge clk);
    check("R8 stall ready", req_ready, 0);
    check("R8 held tval", res_tval, 32'hdead0000);
    check("R8 held cause", res_cause, 15);
    res_ready = 1'b1;
    @(negedge clk);
    check("R8 next result", res_fault, 0);
    check("R7 allowed tval", res_tval, 0);
    req_valid = 1'b0;
    @(negedge clk);

    // R9 fault and ack at same edge
    access = 2'd0; flags = 5'b00001; vaddr = 32'h0badf00d; req_valid = 1'b1; trap_ack = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; trap_ack = 1'b0;
    check("R9 set wins", trapped, 1);
    check("R6 fetch cause", res_cause, 12);
    @(negedge clk);
    check("R9 sticky", trapped, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule